// File: doc/BRIEF.md
# Paged CPU Register File with DMA Override

This block is the processor-side register file of a bus interface controller. A processor reaches eight register offsets through a 3-bit select, a chip enable, a write strobe and a read strobe. The file holds three interrupt banks, each with a status register and a mask register. It also holds a configuration register, an address register, a poll response register, an end-of-string match register, a data-in register and a command/data-out register. Bus handshake logic lies outside this block. The data-in register is loaded from the bus side through `din_we_i`, and the data-out register is presented on `dout_o`.

Two registers, interrupt bank 2 and the end-of-string register, are reachable only after a page-in command has been written to the auxiliary command offset. The paging policy is set by `mode_i`:
- In persistent mode, the paged register sits at offset 2 until another page-in command or a reset.
- In single-access mode, each paged register covers its own base offset for exactly one further processor access.

A DMA grant bypasses the address decode completely. A DMA read returns the data-in register and a DMA write loads the data-out register. The DMA read strobe has the opposite polarity to the processor read strobe.

Top module: `paged_regfile`

## Requirements
- R1: After reset, every register reads 0, the page state is none (offset 3 reads 0), `dout_o` is 0 and `int_low_o` is 0.
- R2: A processor write happens only when `ce_i` and `we_i` are both high and `acc_gr_i` is low. A processor read happens when `ce_i` and `dbin_i` are high and `we_i` and `acc_gr_i` are low. With `ce_i` low and no grant, `rdata_o` is 0 and no register changes.
- R3: With no page active, the base map is as follows:
  - offset 0 reads status bank 0 and a write loads mask bank 0;
  - offset 1 does the same for bank 1;
  - offset 2 is the configuration register, read/write;
  - offset 3 reads the page state in bits [1:0] (0 none, 1 bank 2, 2 end-of-string), and a write is an auxiliary command;
  - offset 4 is the address register, read/write;
  - offset 5 is the poll response register, read/write;
  - offset 6 reads 0 and ignores writes;
  - offset 7 reads data-in and a write loads `dout_o`.
- R4: Writing auxiliary code 0x51 pages in interrupt bank 2 and code 0x52 pages in the end-of-string register. Any other auxiliary code leaves the page state unchanged.
- R5: In persistent mode (`mode_i`=0), the paged register replaces offset 2. Bank 2 is read as its status and written as its mask. The page stays in place across any number of accesses until another page-in command or a reset.
- R6: In single-access mode (`mode_i`=1), paged bank 2 covers offset 4 and the paged end-of-string register covers offset 5. The page is dropped at the end of the next processor read or write; a new page-in command replaces it instead.
- R7: While `acc_gr_i` is high, the following hold regardless of `rsel_i` and `ce_i`:
  - a read (`dbin_i` low, `we_i` low) returns the data-in register;
  - a write (`we_i` and `dbin_i` high) loads `dout_o`;
  - no status bit is cleared and the page state does not change.
- R8: Status bit i of bank k is set by a one-cycle pulse on `evt_i[8k+i]`. A processor read of that bank clears it in the same cycle. A pulse arriving in the cycle of the clearing read wins, so the bit stays set.
- R9: `int_low_o` is high, meaning drive the line low, exactly when some status bit has its mask bit set. It follows the register state combinationally, one edge after the setting pulse or the clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Paging policy: 0 persistent, 1 single-access |
| rsel_i | input | 3 | Register offset select |
| ce_i | input | 1 | Chip enable, active high |
| we_i | input | 1 | Write strobe, active high |
| dbin_i | input | 1 | Read strobe (inverted sense under DMA grant) |
| acc_gr_i | input | 1 | DMA access grant, active high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when no read is in progress |
| din_i | input | 8 | Bus-side data for the data-in register |
| din_we_i | input | 1 | Load strobe for the data-in register |
| dout_o | output | 8 | Command/data-out register |
| evt_i | input | 24 | Interrupt event pulses, 8 per bank |
| int_low_o | output | 1 | Open-drain pull-down enable for the interrupt line |

## Verification
A wrong page state shows up at the very next access to offset 2, 4 or 5, which returns the base register in place of the paged one or the reverse. It also shows immediately as a wrong value at offset 3. A status bit that was not cleared, or was cleared too early, shows in the next read of its bank and in `int_low_o` one edge after the faulty access. A DMA access that leaks into the processor decode shows as a changed configuration register, a lost page or a vanished status bit on the following processor read.

// File: rtl/pr_pkg.sv
package pr_pkg;
  localparam int N_BANK = 3;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    PG_NONE = 2'd0,
    PG_IRQ2 = 2'd1,
    PG_EOS  = 2'd2
  } page_e;

  typedef enum logic [3:0] {
    T_IRQ0, T_IRQ1, T_IRQ2, T_CFG, T_AUX, T_ADDR, T_PPR, T_EOS, T_DATA, T_NONE
  } tgt_e;
endpackage

// File: rtl/pr_decode.sv
module pr_decode
  import pr_pkg::*;
(
  input  logic [SEL_W-1:0] rsel_i,
  input  logic             ce_i,
  input  logic             we_i,
  input  logic             dbin_i,
  input  logic             acc_gr_i,
  input  logic             mode_i,
  input  page_e            page_i,
  output logic             cpu_rd_o,
  output logic             cpu_wr_o,
  output logic             dma_rd_o,
  output logic             dma_wr_o,
  output tgt_e             tgt_o
);
  assign cpu_wr_o = ce_i & we_i & ~acc_gr_i;
  assign cpu_rd_o = ce_i & dbin_i & ~we_i & ~acc_gr_i;
  // read strobe sense is inverted while granted
  assign dma_rd_o = acc_gr_i & ~dbin_i & ~we_i;
  assign dma_wr_o = acc_gr_i & we_i & dbin_i;

  always_comb begin
    case (rsel_i)
      3'd0: tgt_o = T_IRQ0;
      3'd1: tgt_o = T_IRQ1;
      3'd2: tgt_o = (!mode_i && page_i == PG_IRQ2) ? T_IRQ2 :
                    (!mode_i && page_i == PG_EOS)  ? T_EOS  : T_CFG;
      3'd3: tgt_o = T_AUX;
      3'd4: tgt_o = (mode_i && page_i == PG_IRQ2) ? T_IRQ2 : T_ADDR;
      3'd5: tgt_o = (mode_i && page_i == PG_EOS)  ? T_EOS  : T_PPR;
      3'd7: tgt_o = T_DATA;
      default: tgt_o = T_NONE;
    endcase
  end
endmodule

// File: rtl/pr_page.sv
module pr_page
  import pr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AUX_PG_BASE = 'h50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_i,
  input  logic          cpu_acc_i,
  input  logic          aux_wr_i,
  input  logic [DW-1:0] wdata_i,
  output page_e         page_o
);
  localparam logic [DW-1:0] CODE_IRQ2 = DW'(AUX_PG_BASE + 1);
  localparam logic [DW-1:0] CODE_EOS  = DW'(AUX_PG_BASE + 2);

  page_e page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) page_q <= PG_NONE;
    else if (aux_wr_i && wdata_i == CODE_IRQ2) page_q <= PG_IRQ2;
    else if (aux_wr_i && wdata_i == CODE_EOS)  page_q <= PG_EOS;
    else if (mode_i && cpu_acc_i)              page_q <= PG_NONE;
  end

  assign page_o = page_q;
endmodule

// File: rtl/pr_irq.sv
module pr_irq #(
  parameter int DW     = 8,
  parameter int N_BANK = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_BANK*DW-1:0] evt_i,
  input  logic [N_BANK-1:0]    clr_i,
  input  logic [N_BANK-1:0]    mask_we_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [N_BANK*DW-1:0] stat_o,
  output logic                 irq_o
);
  logic [N_BANK-1:0] hit;

  for (genvar k = 0; k < N_BANK; k++) begin : g_bank
    logic [DW-1:0] stat_q, mask_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stat_q <= '0;
        mask_q <= '0;
      end else begin
        // a new event outranks the clearing read
        stat_q <= (stat_q & ~{DW{clr_i[k]}}) | evt_i[k*DW +: DW];
        if (mask_we_i[k]) mask_q <= wdata_i;
      end
    end
    assign stat_o[k*DW +: DW] = stat_q;
    assign hit[k] = |(stat_q & mask_q);
  end

  assign irq_o = |hit;
endmodule

// File: rtl/paged_regfile.sv
module paged_regfile
  import pr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AUX_PG_BASE = 'h50
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 mode_i,
  input  logic [SEL_W-1:0]     rsel_i,
  input  logic                 ce_i,
  input  logic                 we_i,
  input  logic                 dbin_i,
  input  logic                 acc_gr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [DW-1:0]        din_i,
  input  logic                 din_we_i,
  output logic [DW-1:0]        dout_o,
  input  logic [N_BANK*DW-1:0] evt_i,
  output logic                 int_low_o
);
  logic cpu_rd, cpu_wr, dma_rd, dma_wr;
  tgt_e  tgt;
  page_e page_q;
  logic [N_BANK*DW-1:0] stat_q;
  logic [N_BANK-1:0]    clr, mask_we;
  logic [DW-1:0] cfg_q, addr_q, ppr_q, eos_q, din_q, dout_q, mux;

  pr_decode u_dec (
    .rsel_i, .ce_i, .we_i, .dbin_i, .acc_gr_i, .mode_i,
    .page_i(page_q),
    .cpu_rd_o(cpu_rd), .cpu_wr_o(cpu_wr),
    .dma_rd_o(dma_rd), .dma_wr_o(dma_wr),
    .tgt_o(tgt)
  );

  pr_page #(.DW(DW), .AUX_PG_BASE(AUX_PG_BASE)) u_page (
    .clk_i, .rst_ni, .mode_i,
    .cpu_acc_i(cpu_rd | cpu_wr),
    .aux_wr_i(cpu_wr && tgt == T_AUX),
    .wdata_i,
    .page_o(page_q)
  );

  for (genvar k = 0; k < N_BANK; k++) begin : g_sel
    localparam tgt_e TK = tgt_e'(k);
    assign clr[k]     = cpu_rd && tgt == TK;
    assign mask_we[k] = cpu_wr && tgt == TK;
  end

  pr_irq #(.DW(DW), .N_BANK(N_BANK)) u_irq (
    .clk_i, .rst_ni, .evt_i,
    .clr_i(clr), .mask_we_i(mask_we), .wdata_i,
    .stat_o(stat_q), .irq_o(int_low_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; addr_q <= '0; ppr_q <= '0; eos_q <= '0;
      din_q <= '0; dout_q <= '0;
    end else begin
      if (din_we_i) din_q <= din_i;
      if (dma_wr) dout_q <= wdata_i;
      else if (cpu_wr) begin
        case (tgt)
          T_CFG:   cfg_q  <= wdata_i;
          T_ADDR:  addr_q <= wdata_i;
          T_PPR:   ppr_q  <= wdata_i;
          T_EOS:   eos_q  <= wdata_i;
          T_DATA:  dout_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (tgt)
      T_IRQ0:  mux = stat_q[0*DW +: DW];
      T_IRQ1:  mux = stat_q[1*DW +: DW];
      T_IRQ2:  mux = stat_q[2*DW +: DW];
      T_CFG:   mux = cfg_q;
      T_AUX:   mux = {{(DW-2){1'b0}}, page_q};
      T_ADDR:  mux = addr_q;
      T_PPR:   mux = ppr_q;
      T_EOS:   mux = eos_q;
      T_DATA:  mux = din_q;
      default: mux = '0;
    endcase
  end

  assign rdata_o = dma_rd ? din_q : (cpu_rd ? mux : '0);
  assign dout_o  = dout_q;
endmodule

// File: rtl/pr_chk.sv
module pr_chk #(
  parameter int DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mode_i,
  input logic [2:0]      rsel_i,
  input logic            ce_i,
  input logic            we_i,
  input logic            dbin_i,
  input logic            acc_gr_i,
  input logic [3*DW-1:0] evt_i,
  input logic [DW-1:0]   rdata_o,
  input logic [DW-1:0]   dout_o,
  input logic [1:0]      page_q,
  input logic [3*DW-1:0] stat_q
);
  logic wr_c, rd_c, aux_w, dma_w;
  assign wr_c  = ce_i && we_i && !acc_gr_i;
  assign rd_c  = ce_i && dbin_i && !we_i && !acc_gr_i;
  assign aux_w = wr_c && rsel_i == 3'd3;
  assign dma_w = acc_gr_i && we_i && dbin_i;

  p_idle_rdata_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && !acc_gr_i) |-> rdata_o == '0);

  p_persist_page_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && !aux_w) |=> $stable(page_q));

  p_single_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && (wr_c || rd_c) && !aux_w && page_q != 2'd0) |=> page_q == 2'd0);

  p_dma_page_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_gr_i |=> $stable(page_q));

  p_dout_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dma_w && !(wr_c && rsel_i == 3'd7)) |=> $stable(dout_o));

  p_read_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_c && rsel_i == 3'd0 && evt_i[DW-1:0] == '0) |=> stat_q[DW-1:0] == '0);
endmodule

bind paged_regfile pr_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .rsel_i(rsel_i),
  .ce_i(ce_i), .we_i(we_i), .dbin_i(dbin_i), .acc_gr_i(acc_gr_i),
  .evt_i(evt_i), .rdata_o(rdata_o), .dout_o(dout_o),
  .page_q(page_q), .stat_q(stat_q)
);

// File: tb/tb_paged_regfile.sv
module tb_paged_regfile;
  logic clk = 0, rst_ni = 0, mode = 0;
  logic [2:0] rsel = 0;
  logic ce = 0, we = 0, dbin = 0, gr = 0, din_we = 0;
  logic [7:0] wdata = 0, din = 0, rdata, dout;
  logic [23:0] evt = 0;
  logic int_low;
  int total = 0, bad = 0;
  logic [7:0] v;

  always #5 clk = ~clk;

  paged_regfile dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .rsel_i(rsel),
    .ce_i(ce), .we_i(we), .dbin_i(dbin), .acc_gr_i(gr),
    .wdata_i(wdata), .rdata_o(rdata), .din_i(din), .din_we_i(din_we),
    .dout_o(dout), .evt_i(evt), .int_low_o(int_low)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    ce = 0; we = 0; dbin = 0; gr = 0; evt = 0; din_we = 0;
  endtask

  task automatic cpu_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); ce = 1; we = 1; rsel = a; wdata = d;
    @(negedge clk); idle();
  endtask

  task automatic cpu_rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); ce = 1; dbin = 1; rsel = a;
    #1 d = rdata;
    @(negedge clk); idle();
  endtask

  task automatic pulse(logic [23:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); idle();
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      cpu_rd(3'(a), v); chk("R1 reset read", v, 8'h00);
    end
    chk("R1 int", {7'b0, int_low}, 8'h00);
    chk("R1 dout", dout, 8'h00);

    // R3 base map sweep
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pat;
      pat = 8'h1F * 8'(p + 1) ^ 8'hA0;
      cpu_wr(2, pat); cpu_wr(4, ~pat); cpu_wr(5, pat + 8'd3);
      cpu_wr(6, pat); cpu_wr(7, pat ^ 8'h5A);
      cpu_rd(2, v); chk("R3 cfg", v, pat);
      cpu_rd(4, v); chk("R3 addr", v, ~pat);
      cpu_rd(5, v); chk("R3 ppr", v, pat + 8'd3);
      cpu_rd(6, v); chk("R3 reserved", v, 8'h00);
      chk("R3 dout", dout, pat ^ 8'h5A);
    end

    // R2 strobes gated by chip enable
    cpu_wr(2, 8'h3C);
    @(negedge clk); ce = 0; we = 1; rsel = 2; wdata = 8'hFF;
    @(negedge clk); idle(); dbin = 1; rsel = 2;
    #1 chk("R2 read without ce", rdata, 8'h00);
    @(negedge clk); idle();
    cpu_rd(2, v); chk("R2 write without ce", v, 8'h3C);

    // R4/R5 persistent paging of bank 2
    cpu_wr(3, 8'h51);
    cpu_rd(3, v); chk("R4 page id irq2", v, 8'h01);
    cpu_wr(3, 8'h12);
    cpu_rd(3, v); chk("R4 other code ignored", v, 8'h01);

    // R8/R9 sweep every event bit through its bank
    for (int j = 0; j < 24; j++) begin
      logic [2:0] b;
      logic [7:0] bit_v;
      b = 3'(j / 8);
      bit_v = 8'h01 << (j % 8);
      pulse(24'h1 << j);
      chk("R9 masked", {7'b0, int_low}, 8'h00);
      cpu_wr(b, bit_v);
      chk("R9 unmasked", {7'b0, int_low}, 8'h01);
      cpu_rd(b, v); chk("R8 status", v, bit_v);
      chk("R9 after clear", {7'b0, int_low}, 8'h00);
      cpu_rd(b, v); chk("R8 cleared", v, 8'h00);
      cpu_wr(b, 8'h00);
    end
    cpu_rd(3, v); chk("R5 page kept", v, 8'h01);

    // R8 set wins over clearing read
    pulse(24'h8);
    @(negedge clk); ce = 1; dbin = 1; rsel = 0; evt = 24'h8;
    #1 chk("R8 read during event", rdata, 8'h08);
    @(negedge clk); idle();
    cpu_rd(0, v); chk("R8 set wins", v, 8'h08);
    cpu_rd(0, v); chk("R8 then clear", v, 8'h00);

    // R5 eos paged at offset 2
    cpu_wr(3, 8'h52);
    cpu_wr(2, 8'h9A);
    cpu_rd(2, v); chk("R5 eos", v, 8'h9A);
    cpu_rd(2, v); chk("R5 eos persists", v, 8'h9A);
    cpu_rd(3, v); chk("R4 page id eos", v, 8'h02);
    cpu_wr(3, 8'h50);
    cpu_rd(3, v); chk("R4 base code ignored", v, 8'h02);
    cpu_wr(3, 8'h51);
    cpu_rd(2, v); chk("R5 swapped to bank2", v, 8'h00);
    do_reset();
    cpu_rd(3, v); chk("R1 reset cancels page", v, 8'h00);
    cpu_rd(2, v); chk("R1 cfg cleared", v, 8'h00);

    // R6 single-access mode
    mode = 1;
    cpu_wr(4, 8'h44); cpu_wr(5, 8'h55);
    cpu_wr(3, 8'h52); cpu_wr(5, 8'hE5);
    cpu_rd(5, v); chk("R6 base after one access", v, 8'h55);
    cpu_wr(3, 8'h52);
    cpu_rd(5, v); chk("R6 eos overlay", v, 8'hE5);
    cpu_rd(5, v); chk("R6 paged out", v, 8'h55);
    cpu_wr(3, 8'h51);
    cpu_rd(3, v); chk("R6 page id", v, 8'h01);
    cpu_rd(4, v); chk("R6 out after id read", v, 8'h44);
    cpu_rd(2, v); chk("R6 offset2 stays cfg", v, 8'h00);

    // R7 DMA path
    @(negedge clk); din = 8'hA5; din_we = 1;
    @(negedge clk); idle();
    pulse(24'h1 << 16);
    cpu_wr(3, 8'h51);
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); gr = 1; dbin = 0; rsel = 3'(a);
      #1 chk("R7 dma read", rdata, 8'hA5);
      @(negedge clk); idle();
    end
    @(negedge clk); gr = 1; we = 1; dbin = 1; ce = 1; rsel = 4; wdata = 8'h3C;
    @(negedge clk); idle();
    chk("R7 dma write", dout, 8'h3C);
    cpu_rd(4, v); chk("R7 page survives dma", v, 8'h01);
    cpu_rd(4, v); chk("R7 addr untouched", v, 8'h44);
    cpu_rd(7, v); chk("R3 data-in", v, 8'hA5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule